// File: doc/BRIEF.md
# Event Time Capture Unit

This unit watches a small set of external event pins and records the time at which a chosen transition occurs on one of them. A time-of-day counter elsewhere on the chip supplies a live seconds value and a live nanoseconds value. When the selected pin shows the programmed transition and capture is enabled, both values are stored together in one 64-bit word. Seconds sit in the upper half of the word and nanoseconds in the lower half. A sticky flag marks that a new capture has arrived since the last read.

A single configuration register controls the unit. It holds an enable bit, a bit that chooses the rising or the falling transition, and a 6-bit field that picks which event pin is watched. Every pin passes through a flop synchronizer before its transitions are detected. When a new configuration is written, the detector takes the level of the newly selected pin as its reference, so the write itself never produces a capture. Software reads the word and pulses the read strobe, and that strobe clears the flag.

Top module: `evt_stamp_capture`

## Requirements
- R1: While the enable bit (configuration bit 0) is 0, no capture takes place, and `ts_word` and `ts_valid` do not change because of any pin activity.
- R2: Configuration bit 1 selects the capturing transition: 0 captures on a low-to-high change and 1 captures on a high-to-low change. A change in the other direction is ignored.
- R3: Configuration bits 7:2 hold a source number. Source n watches `evt_in[n]`, and the other pins are ignored. A source number of `NUM_SRC` or above watches no pin and never captures.
- R4: A capture stores `{tod_sec, tod_ns}` as sampled at one single clock edge. Seconds go in bits 63:32 and nanoseconds in bits 31:0. A level change on the watched pin that is present at clock edge k is captured at edge k+2, with the time values present at edge k+2.
- R5: Each qualifying transition overwrites the previous capture. When no capture occurs, `ts_word` holds its value, and a read does not alter it.
- R6: `ts_valid` rises with every capture and stays high until a `ts_rd` pulse clears it at the next edge. If a capture and a read happen in the same cycle, the capture wins and the flag stays high.
- R7: A configuration write never causes a capture by itself, even when the newly selected pin is already at the level the new edge setting captures on.
- R8: After reset, `ts_word` is 0, `ts_valid` is 0 and the configuration is 0, which means capture is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_SRC | Asynchronous event pins |
| tod_sec | input | SEC_W | Live seconds value of the time counter |
| tod_ns | input | NS_W | Live nanoseconds value of the time counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | SEL_W+2 | Configuration value: bit 0 enable, bit 1 edge, bits 7:2 source |
| ts_rd | input | 1 | Read strobe that clears the sticky flag |
| ts_word | output | SEC_W+NS_W | Last capture, with seconds in the upper half and nanoseconds in the lower half |
| ts_valid | output | 1 | Sticky flag marking a new capture |

## Verification
A pin change driven just before clock edge k reaches the second synchronizer flop at edge k+1 and is captured at edge k+2. The bench therefore waits three rising edges after driving a pin and samples on the following falling edge. The time inputs are changed on every falling edge around a capture, so only the value present at edge k+2 can match. A configuration write and a read strobe each take effect at the single edge where they are high, and their results are checked on the falling edge right after.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;
   // configuration register field positions
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_EDGE_BIT = 1;
   localparam int CFG_SEL_LSB  = 2;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;
endpackage

// File: rtl/evt_sync_bank.sv
module evt_sync_bank #(
   parameter int NUM_SRC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] async_in,
   output logic [NUM_SRC-1:0] sync_out
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], async_in[g]};
      end
      assign sync_out[g] = chain[SYNC_STAGES-1];
   end
endmodule

// File: rtl/evt_edge_pick.sv
module evt_edge_pick
   import evt_stamp_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lvl_in,
   input  logic [SEL_W-1:0]   sel_cur,
   input  logic [SEL_W-1:0]   sel_nxt,
   input  edge_kind_e         edge_mode,
   input  logic               enable,
   input  logic               hold,
   output logic               cap
);
   logic lvl_cur, lvl_nxt, lvl_prev;

   always_comb begin
      lvl_cur = 1'b0;
      lvl_nxt = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_cur == SEL_W'(i)) lvl_cur = lvl_in[i];
         if (sel_nxt == SEL_W'(i)) lvl_nxt = lvl_in[i];
      end
   end

   // reference level follows the source that is selected after this edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl_nxt;
   end

   always_comb begin
      if (edge_mode == EDGE_FALL) cap = lvl_prev & ~lvl_cur;
      else                        cap = ~lvl_prev & lvl_cur;
      cap = cap & enable & ~hold;
   end
endmodule

// File: rtl/evt_stamp_hold.sv
module evt_stamp_hold #(
   parameter int SEC_W = 32,
   parameter int NS_W  = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap,
   input  logic                  rd,
   input  logic [SEC_W-1:0]      sec_in,
   input  logic [NS_W-1:0]       ns_in,
   output logic [SEC_W+NS_W-1:0] word,
   output logic                  valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else begin
         if (cap) word <= {sec_in, ns_in};
         if (cap)     valid <= 1'b1;
         else if (rd) valid <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_stamp_capture.sv
module evt_stamp_capture
   import evt_stamp_pkg::*;
#(
   parameter int NUM_SRC     = 4,
   parameter int SEL_W       = 6,
   parameter int SEC_W       = 32,
   parameter int NS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    evt_in,
   input  logic [SEC_W-1:0]      tod_sec,
   input  logic [NS_W-1:0]       tod_ns,
   input  logic                  cfg_we,
   input  logic [SEL_W+1:0]      cfg_wdata,
   input  logic                  ts_rd,
   output logic [SEC_W+NS_W-1:0] ts_word,
   output logic                  ts_valid
);
   localparam int CFG_W = SEL_W + 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("evt_stamp_capture: SYNC_STAGES must be at least 2");
   end
   if (NUM_SRC < 1 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("evt_stamp_capture: NUM_SRC out of range for SEL_W");
   end

   logic [CFG_W-1:0]   cfg_r;
   logic               cfg_en;
   edge_kind_e         cfg_edge;
   logic [SEL_W-1:0]   cfg_sel;
   logic [SEL_W-1:0]   sel_nxt;
   logic [NUM_SRC-1:0] evt_sync;
   logic               cap_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_r <= '0;
      else if (cfg_we) cfg_r <= cfg_wdata;
   end

   assign cfg_en   = cfg_r[CFG_EN_BIT];
   assign cfg_edge = edge_kind_e'(cfg_r[CFG_EDGE_BIT]);
   assign cfg_sel  = cfg_r[CFG_SEL_LSB +: SEL_W];
   assign sel_nxt  = cfg_we ? cfg_wdata[CFG_SEL_LSB +: SEL_W] : cfg_sel;

   evt_sync_bank #(
      .NUM_SRC     (NUM_SRC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (evt_in),
      .sync_out (evt_sync)
   );

   evt_edge_pick #(
      .NUM_SRC (NUM_SRC),
      .SEL_W   (SEL_W)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_in    (evt_sync),
      .sel_cur   (cfg_sel),
      .sel_nxt   (sel_nxt),
      .edge_mode (cfg_edge),
      .enable    (cfg_en),
      .hold      (cfg_we),
      .cap       (cap_pulse)
   );

   evt_stamp_hold #(
      .SEC_W (SEC_W),
      .NS_W  (NS_W)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (cap_pulse),
      .rd     (ts_rd),
      .sec_in (tod_sec),
      .ns_in  (tod_ns),
      .word   (ts_word),
      .valid  (ts_valid)
   );
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
   parameter int NUM_SRC = 4,
   parameter int SEL_W   = 6,
   parameter int SEC_W   = 32,
   parameter int NS_W    = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic                  cfg_en,
   input logic [SEL_W-1:0]      cfg_sel,
   input logic                  cap,
   input logic                  ts_rd,
   input logic [SEC_W-1:0]      tod_sec,
   input logic [NS_W-1:0]       tod_ns,
   input logic [SEC_W+NS_W-1:0] ts_word,
   input logic                  ts_valid
);
   AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |-> !cap); // R1
   AST_NO_CAP_BAD_SRC: assert property (@(posedge clk) disable iff (!rst_n) (int'(cfg_sel) >= NUM_SRC) |-> !cap); // R3
   AST_CAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n) cap |=> ts_word == {$past(tod_sec), $past(tod_ns)}); // R4
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !cap |=> $stable(ts_word)); // R5
   AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n) cap |=> ts_valid); // R6
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ts_rd && !cap) |=> !ts_valid); // R6
   AST_NO_CAP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cfg_we |-> !cap); // R7
endmodule

bind evt_stamp_capture evt_stamp_chk #(
   .NUM_SRC (NUM_SRC),
   .SEL_W   (SEL_W),
   .SEC_W   (SEC_W),
   .NS_W    (NS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_en   (cfg_en),
   .cfg_sel  (cfg_sel),
   .cap      (cap_pulse),
   .ts_rd    (ts_rd),
   .tod_sec  (tod_sec),
   .tod_ns   (tod_ns),
   .ts_word  (ts_word),
   .ts_valid (ts_valid)
);

// File: tb/evt_stamp_capture_bench.sv
`timescale 1ns/1ps
module evt_stamp_capture_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  evt_in = '0;
   logic [31:0] tod_sec = '0;
   logic [31:0] tod_ns = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic        ts_rd = 1'b0;
   logic [63:0] ts_word;
   logic        ts_valid;

   int n_chk = 0;
   int n_err = 0;
   logic [63:0] exp_word = '0;

   always #2 clk = ~clk;

   evt_stamp_capture u_evt_stamp_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_in    (evt_in),
      .tod_sec   (tod_sec),
      .tod_ns    (tod_ns),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .ts_rd     (ts_rd),
      .ts_word   (ts_word),
      .ts_valid  (ts_valid)
   );

   typedef struct packed {
      logic [7:0]  cfg;
      logic [3:0]  pre;
      logic [3:0]  post;
      logic [31:0] sec;
      logic [31:0] ns;
      logic        hit;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'h01, 4'h0, 4'h1, 32'd10, 32'd100,       1'b1}, // R2 rising, source 0
      '{8'h03, 4'h1, 4'h0, 32'd11, 32'd200,       1'b1}, // R2 falling, source 0
      '{8'h01, 4'h1, 4'h0, 32'd12, 32'd300,       1'b0}, // R2 wrong direction
      '{8'h09, 4'h0, 4'h4, 32'd13, 32'd400,       1'b1}, // R3 source 2
      '{8'h09, 4'h0, 4'h2, 32'd14, 32'd500,       1'b0}, // R3 other pin ignored
      '{8'h08, 4'h0, 4'h4, 32'd15, 32'd600,       1'b0}, // R1 disabled
      '{8'h15, 4'h0, 4'hF, 32'd16, 32'd700,       1'b0}, // R3 source 5 out of range
      '{8'h0F, 4'h8, 4'h0, 32'd17, 32'd999999999, 1'b1}  // R2 falling, source 3
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_pulse();
      @(negedge clk);
      ts_rd = 1'b1;
      @(negedge clk);
      ts_rd = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired act=running exp=done");
      report();
      $finish;
   end

   initial begin
      settle(3);
      // R8 reset state
      chk("R8 word", ts_word, 64'd0);
      chk("R8 valid", {63'd0, ts_valid}, 64'd1 - 64'd1);
      rst_n = 1'b1;
      evt_in = 4'hF;
      settle(5);
      // R8 configuration is disabled after reset: pin activity captures nothing
      chk("R8 cfg off", {63'd0, ts_valid}, 64'd0);
      evt_in = 4'h0;
      settle(4);

      // table walk
      for (int i = 0; i < NV; i++) begin
         wr_cfg(8'h00);
         @(negedge clk);
         evt_in = VECS[i].pre;
         settle(4);
         wr_cfg(VECS[i].cfg);
         settle(3);
         rd_pulse();
         tod_sec = VECS[i].sec;
         tod_ns = VECS[i].ns;
         evt_in = VECS[i].post;
         repeat (3) @(posedge clk);
         @(negedge clk);
         if (VECS[i].hit) exp_word = {VECS[i].sec, VECS[i].ns};
         chk($sformatf("R1/R2/R3 vec%0d valid", i), {63'd0, ts_valid}, {63'd0, VECS[i].hit});
         chk($sformatf("R4/R5 vec%0d word", i), ts_word, exp_word);
         tod_sec = 32'hDEAD;
         tod_ns = 32'hBEEF;
      end

      // R7: writing a new source already at the high level captures nothing
      wr_cfg(8'h00);
      @(negedge clk);
      evt_in = 4'b0010;
      settle(4);
      rd_pulse();
      wr_cfg(8'h05);
      settle(4);
      chk("R7 sel switch valid", {63'd0, ts_valid}, 64'd0);
      chk("R7 sel switch word", ts_word, exp_word);
      wr_cfg(8'h07);
      settle(4);
      chk("R7 edge switch valid", {63'd0, ts_valid}, 64'd0);
      // falling edge on source 1 now captures
      tod_sec = 32'd40;
      tod_ns = 32'd41;
      evt_in = 4'b0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_word = {32'd40, 32'd41};
      chk("R7 later edge word", ts_word, exp_word);

      // R4: time inputs change every cycle; only the edge k+2 value is kept
      wr_cfg(8'h00);
      settle(4);
      wr_cfg(8'h01);
      rd_pulse();
      evt_in = 4'b0001;
      tod_sec = 32'd1; tod_ns = 32'd5;
      @(negedge clk);
      tod_sec = 32'd2; tod_ns = 32'd6;
      @(negedge clk);
      tod_sec = 32'd7; tod_ns = 32'd999999999;
      @(negedge clk);
      tod_sec = 32'd8; tod_ns = 32'd0;
      exp_word = {32'd7, 32'd999999999};
      chk("R4 single-edge sample", ts_word, exp_word);

      // R6 sticky then cleared by read; word kept (R5)
      settle(5);
      chk("R6 sticky", {63'd0, ts_valid}, 64'd1);
      rd_pulse();
      chk("R6 read clears", {63'd0, ts_valid}, 64'd0);
      chk("R5 read keeps word", ts_word, exp_word);

      // R6 capture wins over a read in the same cycle
      evt_in = 4'b0000;
      settle(4);
      evt_in = 4'b0001;
      tod_sec = 32'd20; tod_ns = 32'd30;
      @(negedge clk);
      @(negedge clk);
      ts_rd = 1'b1;
      @(negedge clk);
      ts_rd = 1'b0;
      exp_word = {32'd20, 32'd30};
      chk("R6 capture beats read", {63'd0, ts_valid}, 64'd1);
      chk("R4 capture word", ts_word, exp_word);

      // R5 overwrite without an intervening read
      evt_in = 4'b0000;
      settle(4);
      tod_sec = 32'd21; tod_ns = 32'd31;
      evt_in = 4'b0001;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_word = {32'd21, 32'd31};
      chk("R5 overwrite word", ts_word, exp_word);
      chk("R5 overwrite valid", {63'd0, ts_valid}, 64'd1);

      report();
      $finish;
   end
endmodule